// File: doc/BRIEF.md
# Local Countdown Timer with Power-of-Two Prescaler

This block is a local interrupt timer. A bus tick input is divided by a power of two chosen through a 4-bit divide code. The divided tick decrements a current-count register. The count starts from a value loaded through an initial-count write strobe. Each time the count runs out, an expiry is added to a saturating pending counter.

A small table of local vector entries describes how the block delivers. Entry 0 belongs to the timer, and each entry holds an 8-bit vector, a mask bit and a one-shot/periodic mode bit. A timer entry that is not masked presents the pending expiries on `irq_req` together with its vector. A consumer drains them one at a time with `irq_ack`.

A global software-enable bit sets how entry writes are treated. Turning it off masks every entry and discards the pending expiries.

Top module: `local_timer`

## Requirements
- R1: After synchronous reset, every vector entry reads back masked with vector 0 and one-shot mode. The divide code, initial count, current count and pending level are zero, software enable is off and `irq_req` is low.
- R2: The divided tick happens once every 2^s bus ticks, where s = ({code[3],code[1:0]} + 1) mod 8. Code bit 2 is ignored, code 4'b1011 divides by 1 and code 0 divides by 2.
- R3: An `init_we` write makes `cur_count` equal `init_wdata` in the next cycle and restarts the prescaler. After that the count drops by exactly one on each divided tick.
- R4: With an initial count of zero, the current count stays zero and no expiry is counted.
- R5: In one-shot mode (entry 0 bit 9 clear), the divided tick that takes the count from 1 to 0 counts one expiry. The count then holds at zero until the next `init_we`.
- R6: In periodic mode (entry 0 bit 9 set), the divided tick at count 1 reloads the initial count in place of reaching zero and counts one expiry.
- R7: The pending level increments by one per expiry and saturates at 2^PW-1 instead of wrapping.
- R8: Entry fields are vector in bits [7:0], mask in bit 8 and periodic in bit 9, and they are read back on `lvt_rdata` for `lvt_sel`. `irq_req` is high exactly when the pending level is nonzero and entry 0 is unmasked, and `irq_vector` shows entry 0's vector. `irq_ack` while `irq_req` is high lowers the pending level by one. An ack together with an expiry leaves the level unchanged, and an ack without a request is ignored.
- R9: Writing `en_wdata`=0 with `en_we` sets the mask bit of every entry and clears the pending level, and this takes priority over a same-cycle expiry. While software enable is off, an entry write is stored with its mask bit forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tick | input | 1 | One-cycle pulse per bus tick |
| div_we | input | 1 | Divide code write strobe |
| div_wdata | input | 4 | Divide code |
| init_we | input | 1 | Initial count write strobe |
| init_wdata | input | CW | Initial count value |
| lvt_we | input | 1 | Vector entry write strobe |
| lvt_sel | input | SELW | Entry index for write and readback |
| lvt_wdata | input | 10 | Entry write value |
| lvt_rdata | output | 10 | Selected entry contents |
| en_we | input | 1 | Software enable write strobe |
| en_wdata | input | 1 | Software enable value |
| irq_ack | input | 1 | Consumer takes one pending expiry |
| cur_count | output | CW | Current count |
| pend_level | output | PW | Number of undelivered expiries |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector of the timer entry |

## Verification
The bench goes after the divide codes one by one, including the ignored bit 2 and the wrap of code 4'b1011 to divide-by-1. A decoder that skipped the modulo or used bit 2 would measure a wrong tick spacing. A one-shot count that reloaded or went on decrementing would show a nonzero count or extra expiries after the first. A pending counter that wrapped would read zero after sixteen expiries and drop the request. An ack collapsing with an expiry, a disable that left the pending level or an entry unmasked, and entry writes during disable that kept mask clear are each probed directly. Random traffic against a cycle model covers the interplay of prescaler restart and mid-count divide changes.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    localparam int VEC_W    = 8;
    localparam int LVT_W    = 10;
    localparam int DIVCFG_W = 4;
    localparam int SHIFT_W  = 3;
    localparam int PRE_W    = (1 << SHIFT_W) - 1;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } lvt_t;

    localparam lvt_t LVT_RESET = '{periodic: 1'b0, mask: 1'b1, vector: '0};

    function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIVCFG_W-1:0] code);
        logic [SHIFT_W-1:0] packed_code;
        packed_code = {code[3], code[1:0]};
        return packed_code + SHIFT_W'(1);
    endfunction

    function automatic logic [PRE_W-1:0] pre_limit(input logic [SHIFT_W-1:0] sh);
        logic [PRE_W:0] full;
        full = ((PRE_W+1)'(1) << sh) - (PRE_W+1)'(1);
        return full[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler
    import ltmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_tick,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               div_tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit    = pre_limit(shift);
    assign div_tick = bus_tick && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart || div_tick) begin
            pre_q <= '0;
        end else if (bus_tick) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          div_tick,
    input  logic          periodic,
    output logic [CW-1:0] count,
    output logic          expire
);
    logic [CW-1:0] init_q;
    logic [CW-1:0] cnt_q;
    logic          at_one;

    assign at_one = (cnt_q == CW'(1));
    assign expire = !load && div_tick && at_one;
    assign count  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            init_q <= load_val;
            cnt_q  <= load_val;
        end else if (div_tick && (cnt_q != '0)) begin
            if (at_one) begin
                cnt_q <= periodic ? init_q : '0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end
endmodule

// File: rtl/ltmr_pending.sv
module ltmr_pending #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [PW-1:0] level
);
    localparam logic [PW-1:0] TOP = {PW{1'b1}};
    logic [PW-1:0] lvl_q;

    assign level = lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl_q <= '0;
        end else if (inc && !dec) begin
            if (lvl_q != TOP) lvl_q <= lvl_q + PW'(1);
        end else if (dec && !inc) begin
            lvl_q <= lvl_q - PW'(1);
        end
    end
endmodule

// File: rtl/local_timer.sv
module local_timer
    import ltmr_pkg::*;
#(
    parameter int CW   = 32,
    parameter int PW   = 4,
    parameter int NENT = 6,
    localparam int SELW = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_tick,
    input  logic                div_we,
    input  logic [DIVCFG_W-1:0] div_wdata,
    input  logic                init_we,
    input  logic [CW-1:0]       init_wdata,
    input  logic                lvt_we,
    input  logic [SELW-1:0]     lvt_sel,
    input  logic [LVT_W-1:0]    lvt_wdata,
    output logic [LVT_W-1:0]    lvt_rdata,
    input  logic                en_we,
    input  logic                en_wdata,
    input  logic                irq_ack,
    output logic [CW-1:0]       cur_count,
    output logic [PW-1:0]       pend_level,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vector
);
    logic [DIVCFG_W-1:0] div_q;
    logic                sw_en_q;
    lvt_t                lvt_q [NENT];
    logic                disabling;
    logic                div_tick;
    logic                expire;
    logic                timer_masked;
    logic                timer_periodic;

    assign disabling      = en_we && !en_wdata;
    assign timer_masked   = lvt_q[0].mask;
    assign timer_periodic = lvt_q[0].periodic;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            sw_en_q <= 1'b0;
        end else begin
            if (div_we) div_q   <= div_wdata;
            if (en_we)  sw_en_q <= en_wdata;
        end
    end

    for (genvar i = 0; i < NENT; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                lvt_q[i] <= LVT_RESET;
            end else if (lvt_we && (lvt_sel == SELW'(i))) begin
                lvt_q[i]      <= lvt_t'(lvt_wdata);
                lvt_q[i].mask <= lvt_wdata[8] || !sw_en_q || disabling;
            end else if (disabling) begin
                lvt_q[i].mask <= 1'b1;
            end
        end
    end

    always_comb begin
        lvt_rdata = '0;
        for (int k = 0; k < NENT; k++) begin
            if (lvt_sel == SELW'(k)) lvt_rdata = LVT_W'(lvt_q[k]);
        end
    end

    ltmr_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .bus_tick (bus_tick),
        .restart  (init_we),
        .shift    (div_shift(div_q)),
        .div_tick (div_tick)
    );

    ltmr_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (init_we),
        .load_val (init_wdata),
        .div_tick (div_tick),
        .periodic (timer_periodic),
        .count    (cur_count),
        .expire   (expire)
    );

    assign irq_req    = (pend_level != '0) && !timer_masked;
    assign irq_vector = lvt_q[0].vector;

    ltmr_pending #(.PW(PW)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .inc   (expire),
        .dec   (irq_req && irq_ack),
        .clr   (disabling),
        .level (pend_level)
    );
endmodule

// File: rtl/local_timer_chk.sv
module local_timer_chk #(
    parameter int CW = 32,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          init_we,
    input logic [CW-1:0] init_wdata,
    input logic [CW-1:0] cur_count,
    input logic          irq_req,
    input logic          irq_ack,
    input logic [PW-1:0] pend_level,
    input logic          expire,
    input logic          periodic,
    input logic          en_we,
    input logic          en_wdata,
    input logic          timer_masked
);
    logic clr;
    assign clr = en_we && !en_wdata;

    // R3: a load is visible in the next cycle
    a_r3_init_loads: assert property (@(posedge clk) disable iff (rst)
        init_we |=> cur_count == $past(init_wdata));

    // R4: a zero count never moves without a load
    a_r4_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (!init_we && cur_count == '0) |=> cur_count == '0);

    // R5: one-shot expiry lands on zero
    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (expire && !periodic && !init_we) |=> cur_count == '0);

    // R7: saturated level stays put
    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (pend_level == {PW{1'b1}} && !(irq_req && irq_ack) && !clr)
        |=> pend_level == {PW{1'b1}});

    // R8: a taken request removes one pending expiry
    a_r8_ack_drains: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && !expire && !clr)
        |=> pend_level == $past(pend_level) - PW'(1));

    // R9: disable clears pending and masks the timer entry
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pend_level == '0) && timer_masked);
endmodule

bind local_timer local_timer_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .init_we      (init_we),
    .init_wdata   (init_wdata),
    .cur_count    (cur_count),
    .irq_req      (irq_req),
    .irq_ack      (irq_ack),
    .pend_level   (pend_level),
    .expire       (expire),
    .periodic     (timer_periodic),
    .en_we        (en_we),
    .en_wdata     (en_wdata),
    .timer_masked (timer_masked)
);

// File: tb/local_timer_tb_top.sv
`timescale 1ns/1ps
module local_timer_tb_top;
    localparam int CW = 32;
    localparam int PW = 4;
    localparam int NENT = 6;
    localparam int SELW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_tick = 0, div_we = 0, init_we = 0, lvt_we = 0, en_we = 0, en_wdata = 0, irq_ack = 0;
    logic [3:0] div_wdata = 0;
    logic [CW-1:0] init_wdata = 0;
    logic [SELW-1:0] lvt_sel = 0;
    logic [9:0] lvt_wdata = 0;
    logic [9:0] lvt_rdata;
    logic [CW-1:0] cur_count;
    logic [PW-1:0] pend_level;
    logic irq_req;
    logic [7:0] irq_vector;

    always #4 clk = ~clk;

    local_timer #(.CW(CW), .PW(PW), .NENT(NENT)) dut_i (
        .clk(clk), .rst(rst), .bus_tick(bus_tick),
        .div_we(div_we), .div_wdata(div_wdata),
        .init_we(init_we), .init_wdata(init_wdata),
        .lvt_we(lvt_we), .lvt_sel(lvt_sel), .lvt_wdata(lvt_wdata), .lvt_rdata(lvt_rdata),
        .en_we(en_we), .en_wdata(en_wdata), .irq_ack(irq_ack),
        .cur_count(cur_count), .pend_level(pend_level),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    int n_checks = 0;
    int n_fails = 0;
    string phase = "R1";

    // reference state
    logic [CW-1:0] m_cnt, m_init;
    int unsigned m_presc;
    logic [3:0] m_div;
    logic m_en;
    logic [9:0] m_lvt [NENT];
    int unsigned m_pend;

    function automatic int unsigned div_of(input logic [3:0] c);
        logic [2:0] s;
        s = 3'({c[3], c[1:0]}) + 3'd1;
        return 32'd1 << s;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_init = 0; m_presc = 0; m_div = 0; m_en = 0; m_pend = 0;
        for (int i = 0; i < NENT; i++) m_lvt[i] = 10'h100;
    endtask

    task automatic model_edge();
        logic dt, ex, req_old, dec, clr;
        dt = bus_tick && (m_presc >= div_of(m_div) - 1);
        ex = 0;
        req_old = (m_pend != 0) && !m_lvt[0][8];
        dec = req_old && irq_ack;
        clr = en_we && !en_wdata;
        if (init_we) begin
            m_cnt = init_wdata; m_init = init_wdata;
        end else if (dt && m_cnt != 0) begin
            if (m_cnt == 1) begin
                ex = 1;
                m_cnt = m_lvt[0][9] ? m_init : '0;
            end else m_cnt = m_cnt - 1;
        end
        if (init_we || dt) m_presc = 0;
        else if (bus_tick) m_presc = m_presc + 1;
        if (clr) m_pend = 0;
        else if (ex && !dec) begin
            if (m_pend < (1 << PW) - 1) m_pend = m_pend + 1;
        end else if (dec && !ex) m_pend = m_pend - 1;
        for (int i = 0; i < NENT; i++) begin
            if (lvt_we && lvt_sel == SELW'(i))
                m_lvt[i] = lvt_wdata | ((!m_en || clr) ? 10'h100 : 10'h000);
            else if (clr) m_lvt[i] = m_lvt[i] | 10'h100;
        end
        if (en_we) m_en = en_wdata;
        if (div_we) m_div = div_wdata;
    endtask

    task automatic compare_all();
        chk("cur_count", cur_count, m_cnt);
        chk("pend_level", 32'(pend_level), m_pend);
        chk("irq_req", 32'(irq_req), 32'((m_pend != 0) && !m_lvt[0][8]));
        chk("irq_vector", 32'(irq_vector), 32'(m_lvt[0][7:0]));
        chk("lvt_rdata", 32'(lvt_rdata), (int'(lvt_sel) < NENT) ? 32'(m_lvt[lvt_sel]) : 32'd0);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        @(negedge clk);
        div_we = 0; init_we = 0; lvt_we = 0; en_we = 0; irq_ack = 0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin bus_tick = 1; step(); end
        bus_tick = 0;
    endtask

    task automatic wr_lvt(input int sel, input logic [9:0] v);
        lvt_we = 1; lvt_sel = SELW'(sel); lvt_wdata = v; step();
        lvt_sel = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        int unsigned seed, cnt_ticks;
        seed = $urandom(32'd2024);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset values
        phase = "R1";
        compare_all();
        for (int s = 0; s < NENT; s++) begin
            lvt_sel = SELW'(s); #1;
            chk("R1 entry masked after reset", 32'(lvt_rdata), 32'h100);
        end
        lvt_sel = 0;
        chk("R1 count zero", cur_count, 0);

        en_we = 1; en_wdata = 1; step();

        // R2 divisor per code
        phase = "R2";
        foreach (div_wdata[i]) ;
        for (int k = 0; k < 9; k++) begin
            logic [3:0] code;
            code = (k < 5) ? 4'(k) : 4'(k + 3);
            div_we = 1; div_wdata = code; step();
            init_we = 1; init_wdata = 2; step();
            cnt_ticks = 0;
            while (cur_count == 2 && cnt_ticks < 300) begin
                bus_tick = 1; step(); cnt_ticks++;
            end
            bus_tick = 0;
            chk("R2 bus ticks per divided tick", cnt_ticks, div_of(code));
        end
        div_we = 1; div_wdata = 4'hB; step();
        init_we = 1; init_wdata = 5; step();
        tick_n(2);
        chk("R2 code 1011 divides by 1", cur_count, 3);

        // R3 prescaler restart on load
        phase = "R3";
        div_we = 1; div_wdata = 4'h1; step();
        init_we = 1; init_wdata = 9; step();
        tick_n(2);
        init_we = 1; init_wdata = 5; step();
        tick_n(3);
        chk("R3 no decrement before full period", cur_count, 5);
        tick_n(1);
        chk("R3 one decrement per divided tick", cur_count, 4);

        // R4 zero initial count
        phase = "R4";
        div_we = 1; div_wdata = 4'hB; step();
        wr_lvt(0, 10'h020);
        init_we = 1; init_wdata = 0; step();
        tick_n(10);
        chk("R4 count stays zero", cur_count, 0);
        chk("R4 no expiry", 32'(pend_level), 0);

        // R5 one-shot
        phase = "R5";
        init_we = 1; init_wdata = 2; step();
        tick_n(2);
        chk("R5 reaches zero", cur_count, 0);
        chk("R5 one expiry", 32'(pend_level), 1);
        tick_n(6);
        chk("R5 sticks at zero", cur_count, 0);
        chk("R5 no further expiry", 32'(pend_level), 1);
        irq_ack = 1; step();

        // R6 periodic
        phase = "R6";
        wr_lvt(0, 10'h220);
        init_we = 1; init_wdata = 3; step();
        tick_n(3);
        chk("R6 reload on wrap", cur_count, 3);
        chk("R6 expiry counted", 32'(pend_level), 1);
        tick_n(3);
        chk("R6 second wrap", 32'(pend_level), 2);

        // R7 saturation
        phase = "R7";
        wr_lvt(0, 10'h341);
        init_we = 1; init_wdata = 1; step();
        tick_n(20);
        chk("R7 saturates", 32'(pend_level), 15);
        chk("R7 masked holds request low", 32'(irq_req), 0);

        // R8 delivery
        phase = "R8";
        wr_lvt(0, 10'h241);
        chk("R8 request when unmasked", 32'(irq_req), 1);
        chk("R8 vector", 32'(irq_vector), 32'h41);
        irq_ack = 1; step();
        chk("R8 ack drains one", 32'(pend_level), 14);
        irq_ack = 1; bus_tick = 1; step(); bus_tick = 0;
        chk("R8 ack with expiry unchanged", 32'(pend_level), 14);
        wr_lvt(0, 10'h341);
        irq_ack = 1; step();
        chk("R8 ack without request ignored", 32'(pend_level), 14);

        // R9 software disable
        phase = "R9";
        en_we = 1; en_wdata = 0; bus_tick = 1; step(); bus_tick = 0;
        chk("R9 pending cleared", 32'(pend_level), 0);
        for (int s = 0; s < NENT; s++) begin
            lvt_sel = SELW'(s); #1;
            chk("R9 entry masked", 32'(lvt_rdata[8]), 1);
        end
        wr_lvt(2, 10'h055);
        lvt_sel = 2; #1;
        chk("R9 write while disabled forced masked", 32'(lvt_rdata), 32'h155);
        lvt_sel = 0;

        // random traffic
        phase = "R6";
        for (int c = 0; c < 4000; c++) begin
            bus_tick = 1'($urandom % 2);
            if ($urandom % 40 == 0) begin init_we = 1; init_wdata = CW'($urandom % 24); end
            if ($urandom % 60 == 0) begin div_we = 1; div_wdata = 4'($urandom); end
            if ($urandom % 50 == 0) begin lvt_we = 1; lvt_sel = SELW'($urandom % NENT); lvt_wdata = 10'($urandom); end
            else lvt_sel = SELW'($urandom % NENT);
            if ($urandom % 150 == 0) begin en_we = 1; en_wdata = 1'($urandom % 4 != 0); end
            irq_ack = 1'($urandom % 3 == 0);
            step();
        end
        bus_tick = 0;
        summary();
    end
endmodule